// File: doc/BRIEF.md
# Half-Bridge Gate Command Gating with Supply Undervoltage Lockout

This block sits between a PWM source and a half-bridge gate driver. It takes two in-phase gate commands, one for the high-side switch and one for the low-side switch, and passes each through to its output one clock later. Before passing them, it applies three protection conditions. Each of the two supplies, the logic supply and the floating high-side supply, arrives as an unsigned digital code. Every code goes through its own hysteresis comparator, which has separate rising and falling thresholds and decides whether that supply is in lockout.

Lockout of the logic supply turns off both outputs. Lockout of the floating supply turns off only the high-side output. When the floating supply recovers, the high-side output stays off until the command shows a new rising edge. A third input flags that the switch node is below its negative transient limit. If this flag stays high for a set number of consecutive cycles, the high-side output is held off for a fixed hold time. A further qualifying transient during that hold starts the hold time again.

Thresholds, the qualification length and the hold length are parameters, in code units and clock cycles. Both channels pass through exactly one register, so their latencies are equal.

Top module: `hbg_gate_top`

## Requirements
- R1: `ho_o` equals `hin_i` and `lo_o` equals `lin_i` from one clock earlier, whenever no protection condition applies. Both channels have this same one-cycle latency.
- R2: If the logic-supply lockout bit `vcc_uv_o` is 1 in a cycle, both `ho_o` and `lo_o` are 0 in the next cycle.
- R3: If the floating-supply lockout bit `vbs_uv_o` is 1 in a cycle, `ho_o` is 0 in the next cycle. `lo_o` keeps following `lin_i`.
- R4: After reset, `vcc_uv_o` = 1, `vbs_uv_o` = 1, `ho_o` = 0 and `lo_o` = 0.
- R5: A lockout bit clears one cycle after its code is at least `UV_RISE`. It sets one cycle after its code is below `UV_FALL`. For any code in between, the bit keeps its previous value.
- R6: When logic-supply lockout ends, both outputs follow their commands again with no new edge needed, provided the high side was armed before the lockout.
- R7: When floating-supply lockout ends, `ho_o` stays 0 while `hin_i` stays high. `ho_o` is allowed to go high only after `hin_i` goes from 0 to 1 while the floating supply is out of lockout.
- R8: A run of `NEG_QUAL` consecutive cycles with `neg_tr_i` = 1 forces `ho_o` to 0 for `NEG_HOLD` cycles. A shorter run has no effect.
- R9: A new qualifying run during a hold restarts the hold time from its full length.
- R10: `neg_tr_i` has no effect on `lo_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hin_i | input | 1 | High-side gate command |
| lin_i | input | 1 | Low-side gate command |
| vcc_code_i | input | CODE_W | Logic supply level code |
| vbs_code_i | input | CODE_W | Floating supply level code |
| neg_tr_i | input | 1 | Switch node below the negative transient limit |
| ho_o | output | 1 | Gated high-side drive |
| lo_o | output | 1 | Gated low-side drive |
| vcc_uv_o | output | 1 | Logic supply in lockout |
| vbs_uv_o | output | 1 | Floating supply in lockout |

## Verification
Codes parked between the two thresholds show whether each comparator keeps its previous state or takes one threshold for the other. Recovery of the floating supply with the high command already high, followed by a low-then-high pulse, separates edge re-arming from level following. Recovery of the logic supply under the same held command shows that the logic-supply path needs no new edge.

Transient runs one cycle shorter than the qualifying length, runs exactly at that length, and a second run in the middle of a hold separate the qualification counter from the hold restart. A pseudo-random command sequence, compared every cycle against a behavioural model, confirms equal latency on both channels.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic {
        SUP_OK    = 1'b0,
        SUP_UNDER = 1'b1
    } sup_state_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } drive_pair_t;

    function automatic sup_state_t hyst_next(sup_state_t cur, logic at_or_above_rise,
                                             logic below_fall);
        sup_state_t nxt;
        nxt = cur;
        if (cur == SUP_UNDER && at_or_above_rise) nxt = SUP_OK;
        else if (cur == SUP_OK && below_fall) nxt = SUP_UNDER;
        return nxt;
    endfunction

endpackage

// File: rtl/hbg_uv_monitor.sv
module hbg_uv_monitor
    import hbg_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int UV_RISE = 89,
    parameter int UV_FALL = 77
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    output logic              uv_o
);
    localparam logic [CODE_W-1:0] RISE_C = CODE_W'(UV_RISE);
    localparam logic [CODE_W-1:0] FALL_C = CODE_W'(UV_FALL);

    sup_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= SUP_UNDER;
        else     st_q <= hyst_next(st_q, code_i >= RISE_C, code_i < FALL_C);
    end

    assign uv_o = (st_q == SUP_UNDER);

    // R5: inside the band or above, an OK supply stays OK
    p_band_keeps_ok_r5: assert property (@(posedge clk) disable iff (rst)
        (!uv_o && code_i >= FALL_C) |=> !uv_o);
    // R5: below rise an under supply stays under
    p_band_keeps_uv_r5: assert property (@(posedge clk) disable iff (rst)
        (uv_o && code_i < RISE_C) |=> uv_o);
endmodule

// File: rtl/hbg_neg_guard.sv
module hbg_neg_guard #(
    parameter int NEG_QUAL = 3,
    parameter int NEG_HOLD = 225
) (
    input  logic clk,
    input  logic rst,
    input  logic neg_tr_i,
    output logic hold_o
);
    localparam int QW = (NEG_QUAL > 1) ? $clog2(NEG_QUAL) : 1;
    localparam int HW = $clog2(NEG_HOLD + 1);
    localparam logic [QW-1:0] QMAX = QW'(NEG_QUAL - 1);
    localparam logic [HW-1:0] HLOAD = HW'(NEG_HOLD);

    logic [QW-1:0] run_q;
    logic [HW-1:0] hold_q;
    logic          fire;

    assign fire = neg_tr_i && (run_q == QMAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            hold_q <= '0;
        end else begin
            if (!neg_tr_i)          run_q <= '0;
            else if (run_q != QMAX) run_q <= run_q + 1'b1;

            if (fire)              hold_q <= HLOAD;
            else if (hold_q != '0) hold_q <= hold_q - 1'b1;
        end
    end

    assign hold_o = (hold_q != '0);

    // R8: a cycle with the flag low ends any qualification run
    p_run_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !neg_tr_i |=> !fire);
    // R9: a qualified run leaves a full-length hold
    p_hold_reload_r9: assert property (@(posedge clk) disable iff (rst)
        fire |=> (hold_q == HLOAD));
endmodule

// File: rtl/hbg_chan_gate.sv
module hbg_chan_gate
    import hbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hin_i,
    input  logic        lin_i,
    input  logic        vcc_uv_i,
    input  logic        vbs_uv_i,
    input  logic        hold_i,
    output drive_pair_t drv_o
);
    logic hin_d_q;
    logic armed_q;
    logic hin_rise;
    logic hi_ok;
    drive_pair_t drv_q;

    assign hin_rise = hin_i && !hin_d_q;
    assign hi_ok    = (armed_q || hin_rise) && !vbs_uv_i && !vcc_uv_i && !hold_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            hin_d_q <= 1'b0;
            armed_q <= 1'b0;
            drv_q   <= '0;
        end else begin
            hin_d_q  <= hin_i;
            armed_q  <= vbs_uv_i ? 1'b0 : (armed_q || hin_rise);
            drv_q.hi <= hin_i && hi_ok;
            drv_q.lo <= lin_i && !vcc_uv_i;
        end
    end

    assign drv_o = drv_q;

    // R7: the high side cannot go high unless armed or freshly edged
    p_rearm_needed_r7: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !hin_rise) |=> !drv_q.hi);
    // R10: low side ignores the transient hold
    p_lo_indep_r10: assert property (@(posedge clk) disable iff (rst)
        !vcc_uv_i |=> (drv_q.lo == $past(lin_i)));
endmodule

// File: rtl/hbg_gate_top.sv
module hbg_gate_top
    import hbg_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int UV_RISE  = 89,
    parameter int UV_FALL  = 77,
    parameter int NEG_QUAL = 3,
    parameter int NEG_HOLD = 225
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hin_i,
    input  logic              lin_i,
    input  logic [CODE_W-1:0] vcc_code_i,
    input  logic [CODE_W-1:0] vbs_code_i,
    input  logic              neg_tr_i,
    output logic              ho_o,
    output logic              lo_o,
    output logic              vcc_uv_o,
    output logic              vbs_uv_o
);
    localparam int NSUP = 2;

    logic [CODE_W-1:0] codes [NSUP];
    logic [NSUP-1:0]   uv;
    logic              hold;
    drive_pair_t       drv;

    assign codes[0] = vcc_code_i;
    assign codes[1] = vbs_code_i;

    for (genvar g = 0; g < NSUP; g++) begin : g_sup
        hbg_uv_monitor #(
            .CODE_W (CODE_W),
            .UV_RISE(UV_RISE),
            .UV_FALL(UV_FALL)
        ) u_mon (
            .clk   (clk),
            .rst   (rst),
            .code_i(codes[g]),
            .uv_o  (uv[g])
        );
    end

    hbg_neg_guard #(
        .NEG_QUAL(NEG_QUAL),
        .NEG_HOLD(NEG_HOLD)
    ) u_guard (
        .clk     (clk),
        .rst     (rst),
        .neg_tr_i(neg_tr_i),
        .hold_o  (hold)
    );

    hbg_chan_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .hin_i   (hin_i),
        .lin_i   (lin_i),
        .vcc_uv_i(uv[0]),
        .vbs_uv_i(uv[1]),
        .hold_i  (hold),
        .drv_o   (drv)
    );

    assign ho_o     = drv.hi;
    assign lo_o     = drv.lo;
    assign vcc_uv_o = uv[0];
    assign vbs_uv_o = uv[1];

    p_vcc_uv_off_r2: assert property (@(posedge clk) disable iff (rst)
        vcc_uv_o |=> (!ho_o && !lo_o));
    p_vbs_uv_off_r3: assert property (@(posedge clk) disable iff (rst)
        vbs_uv_o |=> !ho_o);
    p_hold_off_r8: assert property (@(posedge clk) disable iff (rst)
        hold |=> !ho_o);
    p_hi_latency_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(ho_o) |-> $past(hin_i));
endmodule

// File: tb/hbg_gate_top_test.sv
module hbg_gate_top_test;
    localparam int CW = 8, RISE = 89, FALL = 77, QUAL = 3, HOLD = 225;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hin = 1'b0, lin = 1'b0, neg = 1'b0;
    logic [CW-1:0] vcc = '0, vbs = '0;
    logic ho, lo, vcc_uv, vbs_uv;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hbg_gate_top #(.CODE_W(CW), .UV_RISE(RISE), .UV_FALL(FALL),
                   .NEG_QUAL(QUAL), .NEG_HOLD(HOLD)) uut (
        .clk(clk), .rst(rst), .hin_i(hin), .lin_i(lin),
        .vcc_code_i(vcc), .vbs_code_i(vbs), .neg_tr_i(neg),
        .ho_o(ho), .lo_o(lo), .vcc_uv_o(vcc_uv), .vbs_uv_o(vbs_uv));

    // behavioural reference
    int m_uvc = 1, m_uvb = 1, m_arm = 0, m_prev = 0, m_run = 0, m_hold = 0;
    int m_ho = 0, m_lo = 0;

    always @(posedge clk) begin
        int uvc, uvb, arm, run, hld, edge_seen, trig;
        if (rst) begin
            m_uvc = 1; m_uvb = 1; m_arm = 0; m_prev = 0; m_run = 0; m_hold = 0;
            m_ho = 0; m_lo = 0;
        end else begin
            edge_seen = (hin && m_prev == 0) ? 1 : 0;
            run = neg ? m_run + 1 : 0;
            trig = (neg && run >= QUAL) ? 1 : 0;
            m_lo = (lin && m_uvc == 0) ? 1 : 0;
            m_ho = (hin && (m_arm == 1 || edge_seen == 1) && m_uvb == 0 && m_uvc == 0
                    && m_hold == 0) ? 1 : 0;
            arm = (m_uvb == 1) ? 0 : ((m_arm == 1 || edge_seen == 1) ? 1 : 0);
            hld = trig ? HOLD : (m_hold > 0 ? m_hold - 1 : 0);
            uvc = m_uvc; uvb = m_uvb;
            if (uvc == 1 && int'(vcc) >= RISE) uvc = 0;
            else if (uvc == 0 && int'(vcc) < FALL) uvc = 1;
            if (uvb == 1 && int'(vbs) >= RISE) uvb = 0;
            else if (uvb == 0 && int'(vbs) < FALL) uvb = 1;
            m_uvc = uvc; m_uvb = uvb; m_arm = arm; m_run = run; m_hold = hld;
            m_prev = hin ? 1 : 0;
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(ho, m_ho[0], "R1 ho vs model");
            chk(lo, m_lo[0], "R1 lo vs model");
            chk(vcc_uv, m_uvc[0], "R5 vcc_uv vs model");
            chk(vbs_uv, m_uvb[0], "R5 vbs_uv vs model");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] lf;
        lf = 8'h5A;
        cyc(3);
        rst = 1'b0;
        hin = 1'b1; lin = 1'b1;
        cyc(1);
        // R4: reset state
        chk(vcc_uv, 1'b1, "R4 vcc_uv after reset");
        chk(vbs_uv, 1'b1, "R4 vbs_uv after reset");
        chk(ho, 1'b0, "R4 ho after reset");
        chk(lo, 1'b0, "R4 lo after reset");
        // R5: a code between the thresholds does not leave lockout
        vcc = 8'd85; vbs = 8'd85;
        cyc(3);
        chk(vcc_uv, 1'b1, "R5 vcc between thresholds");
        chk(vbs_uv, 1'b1, "R5 vbs between thresholds");
        vcc = 8'd89; vbs = 8'd100;
        cyc(2);
        chk(vcc_uv, 1'b0, "R5 vcc at rise threshold");
        chk(lo, 1'b1, "R6 lo follows after vcc recovery");
        // R7: hin held high from before recovery
        cyc(3);
        chk(ho, 1'b0, "R7 ho waits for fresh edge");
        hin = 1'b0; cyc(1);
        hin = 1'b1; cyc(1);
        chk(ho, 1'b1, "R7 ho after fresh edge");
        // R1: pseudo-random commands
        for (int i = 0; i < 60; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            hin = lf[0]; lin = lf[1];
            cyc(1);
            chk(ho, lf[0], "R1 ho one-cycle latency");
            chk(lo, lf[1], "R1 lo one-cycle latency");
        end
        // R3 and R5: floating supply drop
        hin = 1'b1; lin = 1'b1;
        vbs = 8'd77; cyc(3);
        chk(vbs_uv, 1'b0, "R5 vbs at fall threshold stays ok");
        vbs = 8'd70; cyc(2);
        chk(ho, 1'b0, "R3 ho off in vbs lockout");
        chk(lo, 1'b1, "R3 lo still driven in vbs lockout");
        lin = 1'b0; cyc(1);
        chk(lo, 1'b0, "R3 lo follows lin in vbs lockout");
        lin = 1'b1;
        vbs = 8'd100; cyc(4);
        chk(ho, 1'b0, "R7 ho low after vbs recovery with hin high");
        hin = 1'b0; cyc(1); hin = 1'b1; cyc(1);
        chk(ho, 1'b1, "R7 ho rearmed");
        // R2 / R6: logic supply drop and recovery
        vcc = 8'd60; cyc(2);
        chk(ho, 1'b0, "R2 ho off in vcc lockout");
        chk(lo, 1'b0, "R2 lo off in vcc lockout");
        vcc = 8'd120; cyc(2);
        chk(ho, 1'b1, "R6 ho follows after vcc recovery");
        chk(lo, 1'b1, "R6 lo follows after vcc recovery");
        // R8: a short run is ignored
        neg = 1'b1; cyc(QUAL - 1); neg = 1'b0; cyc(3);
        chk(ho, 1'b1, "R8 short transient ignored");
        // R8/R10: a qualifying run
        neg = 1'b1; cyc(QUAL); neg = 1'b0; cyc(2);
        chk(ho, 1'b0, "R8 ho held off");
        chk(lo, 1'b1, "R10 lo unaffected by transient");
        cyc(100);
        // R9: retrigger mid-hold
        neg = 1'b1; cyc(QUAL); neg = 1'b0;
        cyc(HOLD - 100 + 10);
        chk(ho, 1'b0, "R9 hold restarted");
        cyc(110);
        chk(ho, 1'b1, "R8 ho back after hold");
        cyc(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule